// File: doc/BRIEF.md
# Cartridge Bank Controller with Latched Real-Time Clock

This block sits between a CPU's cartridge address space and the cartridge's ROM and RAM. Writes to four control regions pick the ROM bank, open or close the external window, choose between a RAM bank and a clock register for that window, and drive a two-step latch handshake. A real-time clock inside the block counts seconds, minutes, hours and a 9-bit day number from a one-pulse-per-second tick. It keeps a sticky overflow flag and a halt flag.

The CPU never reads the running counters directly. A latch operation copies them into a frozen snapshot. Reads of the external window return either that snapshot, for the selected clock register, or the data coming back from the selected RAM bank. Only the top three address bits reach the block, because they are enough to decode every region it serves.

Top module: `cart_bank_rtc`

## Requirements
- R1: A write with addr_rgn = 3'b001 sets rom_bank to wdata[6:0], and a result of zero becomes 1. After reset rom_bank is 1.
- R2: A write with addr_rgn = 3'b000 opens the external window for data 0x0A and closes it for data 0x00. Any other value changes nothing. The window is closed after reset.
- R3: A write with addr_rgn = 3'b010 and data 0x00 to 0x03 sets ram_bank to wdata[1:0] and selects RAM mode. ram_en is high exactly when the window is open and RAM mode is selected.
- R4: A write with addr_rgn = 3'b010 and data 0x08 to 0x0C selects clock mode and clock register (data minus 8). Any other data leaves the bank, the mode and the register choice unchanged.
- R5: A write of 0x01 with addr_rgn = 3'b011 copies all live counters into the snapshot, but only when no latch is held, and then marks a latch as held. A write of 0x00 there releases the hold. No latch is held after reset.
- R6: Each cycle with sec_tick high and halt clear advances seconds by one. A field at or above its last value (59 seconds, 59 minutes, 23 hours) wraps to 0 and carries into the next field, and hours carry into the 9-bit day count.
- R7: A carry out of day 511 wraps the day count to 0 and sets the overflow flag. The flag stays set until clock register 4 is written.
- R8: Clock register 4 reads as bit 0 = day bit 8, bit 6 = halt, bit 7 = overflow, with the other bits zero. While halt is set, ticks do not change any counter.
- R9: A write with addr_rgn = 3'b101, while the window is open and clock mode is selected, loads the selected live register: register 0 takes seconds from data [5:0], register 1 takes minutes from [5:0], register 2 takes hours from [4:0], register 3 takes day bits [7:0], and register 4 uses the layout of R8. Such a write is ignored while the window is closed. If it falls in the same cycle as a tick, the tick is dropped.
- R10: rdata is 0xFF unless addr_rgn = 3'b101 and the window is open. In that case it is the snapshot of the selected clock register in clock mode (unused high bits zero), and ram_rdata in RAM mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr_rgn | input | 3 | CPU address bits 15 to 13 |
| wdata | input | 8 | CPU write data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| ram_rdata | input | 8 | Data returned by the external RAM |
| rom_bank | output | 7 | Selected switchable ROM bank |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_en | output | 1 | External RAM may be accessed |
| rdata | output | 8 | Read data for the external window |

## Verification
The hardest state to reach is the day overflow, because a free-running clock would need 512 days of ticks to get there. The stimulus loads each live counter at its last value through clock-register writes, then issues a single tick, so the whole carry chain ripples into the sticky flag in one cycle. A second tick and a further latch then show that the flag survives. The latch hold is tested by sending a second 0x01 without a release and showing that the snapshot stays stale. The same-cycle collision between a register write and a tick is driven on purpose, to show that the write wins.

// File: rtl/cart_rtc_pkg.sv
package cart_rtc_pkg;

    localparam int ROM_BANK_W = 7;
    localparam int RAM_BANK_W = 2;
    localparam int DAY_W      = 9;
    localparam int SEL_W      = 3;
    localparam int SEC_W      = 6;
    localparam int MIN_W      = 6;
    localparam int HOUR_W     = 5;

    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);

    localparam logic [7:0] OPEN_KEY  = 8'h0A;
    localparam logic [7:0] CLOSE_KEY = 8'h00;
    localparam logic [7:0] RAM_SEL_TOP = 8'h03;
    localparam logic [7:0] CLK_SEL_LO  = 8'h08;
    localparam logic [7:0] CLK_SEL_HI  = 8'h0C;
    localparam logic [7:0] LATCH_ARM   = 8'h00;
    localparam logic [7:0] LATCH_FIRE  = 8'h01;

    typedef enum logic [2:0] {
        RGN_GATE   = 3'd0,
        RGN_ROM    = 3'd1,
        RGN_SELECT = 3'd2,
        RGN_LATCH  = 3'd3,
        RGN_EXT    = 3'd5
    } ctrl_rgn_e;

    typedef struct packed {
        logic              ovf;
        logic              halt;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } clk_time_t;

    typedef struct packed {
        logic             wr;
        logic [SEL_W-1:0] sel;
        logic [7:0]       data;
    } clk_load_t;

    // Byte view of one clock register as seen by the CPU.
    function automatic logic [7:0] clk_view(clk_time_t t, logic [SEL_W-1:0] idx);
        logic [7:0] v;
        case (idx)
            3'd0:    v = 8'(t.sec);
            3'd1:    v = 8'(t.min);
            3'd2:    v = 8'(t.hour);
            3'd3:    v = t.day[7:0];
            3'd4:    v = {t.ovf, t.halt, 5'b0, t.day[DAY_W-1]};
            default: v = 8'hFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
    import cart_rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            addr_rgn,
    input  logic [7:0]            wdata,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  win_open,
    output logic                  clk_mode,
    output logic [SEL_W-1:0]      clk_sel,
    output logic                  latch_fire,
    output logic                  latch_arm,
    output clk_load_t             load
);
    ctrl_rgn_e rgn;
    logic      hit_gate, hit_rom, hit_sel, hit_latch, hit_ext;
    logic      sel_ram, sel_clk;

    assign rgn       = ctrl_rgn_e'(addr_rgn);
    assign hit_gate  = wr_en && (rgn == RGN_GATE);
    assign hit_rom   = wr_en && (rgn == RGN_ROM);
    assign hit_sel   = wr_en && (rgn == RGN_SELECT);
    assign hit_latch = wr_en && (rgn == RGN_LATCH);
    assign hit_ext   = wr_en && (rgn == RGN_EXT);

    assign sel_ram = hit_sel && (wdata <= RAM_SEL_TOP);
    assign sel_clk = hit_sel && (wdata >= CLK_SEL_LO) && (wdata <= CLK_SEL_HI);

    assign latch_fire = hit_latch && (wdata == LATCH_FIRE);
    assign latch_arm  = hit_latch && (wdata == LATCH_ARM);

    assign load.wr   = hit_ext && win_open && clk_mode;
    assign load.sel  = clk_sel;
    assign load.data = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
            win_open <= 1'b0;
            clk_mode <= 1'b0;
            clk_sel  <= '0;
        end else begin
            if (hit_gate) begin
                if (wdata == OPEN_KEY)
                    win_open <= 1'b1;
                else if (wdata == CLOSE_KEY)
                    win_open <= 1'b0;
            end
            if (hit_rom)
                rom_bank <= (wdata[ROM_BANK_W-1:0] == '0) ? ROM_BANK_W'(1)
                                                          : wdata[ROM_BANK_W-1:0];
            if (sel_ram) begin
                ram_bank <= wdata[RAM_BANK_W-1:0];
                clk_mode <= 1'b0;
            end else if (sel_clk) begin
                // 0x08..0x0C: the low three bits are already value minus 8
                clk_sel  <= wdata[SEL_W-1:0];
                clk_mode <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cart_rtc_core.sv
module cart_rtc_core
    import cart_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_tick,
    input  clk_load_t load,
    output clk_time_t live
);
    clk_time_t       adv;
    logic            c_sec, c_min, c_hour;
    logic [DAY_W:0]  day_sum;

    always_comb begin
        adv     = live;
        c_sec   = (live.sec  >= SEC_LAST);
        c_min   = c_sec && (live.min >= MIN_LAST);
        c_hour  = c_min && (live.hour >= HOUR_LAST);
        day_sum = {1'b0, live.day} + (DAY_W+1)'(1);

        adv.sec = c_sec ? '0 : live.sec + SEC_W'(1);
        if (c_sec)
            adv.min = c_min ? '0 : live.min + MIN_W'(1);
        if (c_min)
            adv.hour = c_hour ? '0 : live.hour + HOUR_W'(1);
        if (c_hour) begin
            adv.day = day_sum[DAY_W-1:0];
            if (day_sum[DAY_W])
                adv.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (load.wr) begin
            case (load.sel)
                3'd0: live.sec           <= load.data[SEC_W-1:0];
                3'd1: live.min           <= load.data[MIN_W-1:0];
                3'd2: live.hour          <= load.data[HOUR_W-1:0];
                3'd3: live.day[7:0]      <= load.data;
                3'd4: begin
                    live.day[DAY_W-1] <= load.data[0];
                    live.halt         <= load.data[6];
                    live.ovf          <= load.data[7];
                end
                default: ;
            endcase
        end else if (sec_tick && !live.halt) begin
            live <= adv;
        end
    end

endmodule

// File: rtl/cart_rtc_latch.sv
module cart_rtc_latch
    import cart_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      latch_fire,
    input  logic      latch_arm,
    input  clk_time_t live,
    output clk_time_t snap,
    output logic      held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
            held <= 1'b0;
        end else if (latch_fire && !held) begin
            snap <= live;
            held <= 1'b1;
        end else if (latch_arm && held) begin
            held <= 1'b0;
        end
    end

endmodule

// File: rtl/cart_bank_rtc.sv
module cart_bank_rtc
    import cart_rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            addr_rgn,
    input  logic [7:0]            wdata,
    input  logic                  sec_tick,
    input  logic [7:0]            ram_rdata,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en,
    output logic [7:0]            rdata
);
    logic             win_open, clk_mode, held;
    logic             latch_fire, latch_arm;
    logic [SEL_W-1:0] clk_sel;
    clk_load_t        load;
    clk_time_t        live, snap;

    cart_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr_rgn   (addr_rgn),
        .wdata      (wdata),
        .rom_bank   (rom_bank),
        .ram_bank   (ram_bank),
        .win_open   (win_open),
        .clk_mode   (clk_mode),
        .clk_sel    (clk_sel),
        .latch_fire (latch_fire),
        .latch_arm  (latch_arm),
        .load       (load)
    );

    cart_rtc_core u_core (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .load     (load),
        .live     (live)
    );

    cart_rtc_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .latch_fire (latch_fire),
        .latch_arm  (latch_arm),
        .live       (live),
        .snap       (snap),
        .held       (held)
    );

    assign ram_en = win_open && !clk_mode;

    always_comb begin
        if ((addr_rgn != RGN_EXT) || !win_open)
            rdata = 8'hFF;
        else if (clk_mode)
            rdata = clk_view(snap, clk_sel);
        else
            rdata = ram_rdata;
    end

endmodule

// File: rtl/cart_bank_rtc_checker.sv
module cart_bank_rtc_checker
    import cart_rtc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [2:0]            addr_rgn,
    input logic [7:0]            wdata,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [RAM_BANK_W-1:0] ram_bank,
    input logic                  win_open,
    input logic                  clk_mode,
    input logic [SEL_W-1:0]      clk_sel,
    input logic                  held,
    input clk_time_t             live,
    input clk_time_t             snap,
    input logic [7:0]            rdata
);
    logic ext_load, reg4_load;
    assign ext_load  = wr_en && (addr_rgn == 3'd5) && win_open && clk_mode;
    assign reg4_load = ext_load && (clk_sel == 3'd4);

    assert_rom_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        rom_bank != '0);

    assert_bank_pick_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_rgn == 3'd2 && wdata <= 8'h03)
        |=> (ram_bank == $past(wdata[RAM_BANK_W-1:0]) && !clk_mode));

    assert_latch_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_rgn == 3'd3 && wdata == 8'h01 && !held)
        |=> (held && snap == $past(live)));

    assert_latch_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (held && !(wr_en && addr_rgn == 3'd3 && wdata == 8'h00))
        |=> (held && $stable(snap)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (live.ovf && !reg4_load) |=> live.ovf);

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (live.halt && !ext_load) |=> $stable(live));

    assert_closed_read_R10: assert property (@(posedge clk) disable iff (rst)
        !win_open |-> rdata == 8'hFF);

endmodule

bind cart_bank_rtc cart_bank_rtc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr_rgn (addr_rgn),
    .wdata    (wdata),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .win_open (win_open),
    .clk_mode (clk_mode),
    .clk_sel  (clk_sel),
    .held     (held),
    .live     (live),
    .snap     (snap),
    .rdata    (rdata)
);

// File: tb/cart_bank_rtc_bench.sv
`timescale 1ns/1ps
module cart_bank_rtc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr_rgn = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic       sec_tick = 1'b0;
    logic [7:0] ram_rdata = 8'h5A;
    logic [6:0] rom_bank;
    logic [1:0] ram_bank;
    logic       ram_en;
    logic [7:0] rdata;

    always #2 clk = ~clk;

    cart_bank_rtc u_cart_bank_rtc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_rgn(addr_rgn),
        .wdata(wdata), .sec_tick(sec_tick), .ram_rdata(ram_rdata),
        .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
        .rdata(rdata)
    );

    // Output selectors for scoreboard items
    localparam int O_RDATA = 0, O_ROM = 1, O_RAMB = 2, O_RAMEN = 3;

    typedef struct {
        int         which;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.which)
                    O_ROM:   act = {1'b0, rom_bank};
                    O_RAMB:  act = {6'b0, ram_bank};
                    O_RAMEN: act = {7'b0, ram_en};
                    default: act = rdata;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_rgn = a[15:13]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input int which, input logic [15:0] a,
                              input logic [7:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        addr_rgn = a[15:13];
        it.which = which; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic clk_load(input logic [2:0] idx, input logic [7:0] d);
        cpu_wr(16'h4000, 8'h08 + 8'(idx));
        cpu_wr(16'hA000, d);
    endtask

    task automatic relatch();
        cpu_wr(16'h6000, 8'h00);
        cpu_wr(16'h6000, 8'h01);
    endtask

    task automatic expect_clk(input logic [2:0] idx, input logic [7:0] e,
                              input string tag);
        cpu_wr(16'h4000, 8'h08 + 8'(idx));
        expect_out(O_RDATA, 16'hA000, e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        expect_out(O_ROM,   16'h0000, 8'h01, "R1 reset bank");
        expect_out(O_RAMEN, 16'h0000, 8'h00, "R2 reset closed");
        expect_out(O_RDATA, 16'hA000, 8'hFF, "R10 closed read");
        expect_out(O_RAMB,  16'h0000, 8'h00, "R3 reset ram bank");

        // ROM bank register
        cpu_wr(16'h2000, 8'h00); expect_out(O_ROM, 16'h0000, 8'h01, "R1 zero to one");
        cpu_wr(16'h3FFF, 8'h85); expect_out(O_ROM, 16'h0000, 8'h05, "R1 bit7 dropped");
        cpu_wr(16'h2000, 8'h7F); expect_out(O_ROM, 16'h0000, 8'h7F, "R1 top bank");
        cpu_wr(16'h2000, 8'h80); expect_out(O_ROM, 16'h0000, 8'h01, "R1 low bits zero");

        // Window gate and RAM path
        cpu_wr(16'h0000, 8'h0A);
        expect_out(O_RAMEN, 16'h0000, 8'h01, "R2 open");
        expect_out(O_RDATA, 16'hA000, 8'h5A, "R10 ram data");

        // Clock: load seconds, first latch without a prior release
        clk_load(3'd0, 8'd58);
        expect_out(O_RAMEN, 16'h0000, 8'h00, "R4 clock mode closes ram");
        cpu_wr(16'h6000, 8'h01);
        expect_out(O_RDATA, 16'hA000, 8'h3A, "R5 first latch / R9 load");
        tick_n(2);
        cpu_wr(16'h6000, 8'h01);
        expect_out(O_RDATA, 16'hA000, 8'h3A, "R5 held latch ignores 1");
        relatch();
        expect_out(O_RDATA, 16'hA000, 8'h00, "R6 seconds wrap");
        expect_clk(3'd1, 8'h01, "R6 minute carry");

        // Full carry chain into day overflow
        clk_load(3'd0, 8'd59); clk_load(3'd1, 8'd59); clk_load(3'd2, 8'd23);
        clk_load(3'd3, 8'hFF); clk_load(3'd4, 8'h01);
        tick_n(1);
        relatch();
        expect_clk(3'd4, 8'h80, "R7 overflow set");
        expect_clk(3'd3, 8'h00, "R7 day wrapped");
        expect_clk(3'd2, 8'h00, "R6 hour wrap");
        tick_n(1);
        relatch();
        expect_clk(3'd4, 8'h80, "R7 overflow sticky");
        expect_clk(3'd0, 8'h01, "R6 tick after overflow");

        // Halt
        clk_load(3'd4, 8'h40);
        tick_n(3);
        relatch();
        expect_clk(3'd0, 8'h01, "R8 halt freezes");
        expect_clk(3'd4, 8'h40, "R8 halt bit / R7 cleared by write");
        clk_load(3'd4, 8'h00);
        tick_n(1);
        relatch();
        expect_clk(3'd0, 8'h02, "R6 resume count");

        // Register 4 bit 0 holds day bit 8
        clk_load(3'd3, 8'h10); clk_load(3'd4, 8'h01);
        relatch();
        expect_clk(3'd4, 8'h01, "R8 day bit8 field");
        expect_clk(3'd3, 8'h10, "R9 day low load");

        // Day carry from 0xFF into bit 8
        clk_load(3'd0, 8'd59); clk_load(3'd1, 8'd59); clk_load(3'd2, 8'd23);
        clk_load(3'd3, 8'hFF); clk_load(3'd4, 8'h00);
        tick_n(1);
        relatch();
        expect_clk(3'd4, 8'h01, "R6 carry into day bit8");
        expect_clk(3'd3, 8'h00, "R6 day low wrap");

        // Write and tick in the same cycle: write wins
        cpu_wr(16'h4000, 8'h08);
        @(negedge clk);
        wr_en = 1'b1; addr_rgn = 3'd5; wdata = 8'h10; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        relatch();
        expect_out(O_RDATA, 16'hA000, 8'h10, "R9 write beats tick");

        // Closed window: reads 0xFF and clock writes ignored
        cpu_wr(16'h0000, 8'h00);
        expect_out(O_RDATA, 16'hA000, 8'hFF, "R2 closed read");
        cpu_wr(16'hA000, 8'h2A);
        cpu_wr(16'h0000, 8'h0A);
        relatch();
        expect_out(O_RDATA, 16'hA000, 8'h10, "R9 closed write ignored");
        cpu_wr(16'h0000, 8'h05);
        expect_out(O_RDATA, 16'hA000, 8'h10, "R2 other value ignored");

        // Back to RAM mode
        cpu_wr(16'h4000, 8'h02);
        expect_out(O_RAMB,  16'h0000, 8'h02, "R3 bank select");
        expect_out(O_RAMEN, 16'h0000, 8'h01, "R3 ram mode");
        expect_out(O_RDATA, 16'hBFFF, 8'h5A, "R10 ram data top");
        expect_out(O_RDATA, 16'h9FFF, 8'hFF, "R10 outside window");
        cpu_wr(16'h4000, 8'h06);
        expect_out(O_RAMB,  16'h0000, 8'h02, "R4 0x06 ignored bank");
        expect_out(O_RAMEN, 16'h0000, 8'h01, "R4 0x06 ignored mode");
        cpu_wr(16'h4000, 8'h0D);
        expect_out(O_RAMEN, 16'h0000, 8'h01, "R4 0x0D ignored");
        cpu_wr(16'h4000, 8'h0C);
        expect_out(O_RAMEN, 16'h0000, 8'h00, "R4 register 4 select");
        expect_out(O_RDATA, 16'hA000, 8'h01, "R10 snapshot view");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule